// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Pulse Generator

This block is a watchdog with an 8-bit up-counter, a timer control byte and a reset control byte, all reached over a small byte-addressed bus. Software arms watchdog operation by setting a mode bit and an enable bit. After that it must keep rewriting the counter, normally back to zero, before the counter wraps past its top value. Each advance of the counter needs a single-cycle count-enable tick on an input.

If the counter wraps while watchdog operation is armed, the block does three things:
- It sets a sticky overflow flag.
- It drives an external overflow pulse for 128 clock cycles.
- If the reset enable bit is set, it also drives an internal reset pulse for 512 clock cycles. This pulse starts on the same cycle as the overflow pulse. It appears on one of two outputs, power-on type or manual type, chosen by a select bit.

Every write is a 16-bit word write. Its upper byte is a key, and a word with a key the block does not accept is dropped. The asynchronous active-low reset input clears all state and overrides a wrap that happens at the same moment. The internal reset pulse clears none of the block's own registers.

Top module: `wdt_rstctl`

## Requirements
- R1: After the external reset `rst_n` is released, every readable byte reads 0x00, and all three pulse outputs are low.
- R2: Reads are byte reads, combinational on `addr`:
  - offset 0 returns the timer control byte: bit 6 is the mode bit, bit 5 is the enable bit, and all other bits are 0.
  - offset 1 returns the counter.
  - offset 3 returns the reset control byte: bit 7 is the overflow flag, bit 6 is the reset enable, bit 5 is the reset type select, and all other bits are 0.
  - offset 2 returns 0x00.
- R3: A word write to offset 0 with key 0xA5 loads the mode bit from data bit 6 and the enable bit from data bit 5. The same write with key 0x5A loads the counter with the low byte.
- R4: A word write to offset 2 with key 0x5A loads the reset enable from data bit 6 and the type select from data bit 5. It leaves the overflow flag unchanged.
- R5: A word write to offset 2 with key 0xA5 and low byte 0x00 clears only the overflow flag. With key 0xA5 and a nonzero low byte, the write changes nothing. No write can set the flag.
- R6: A write with any other key, or to an odd offset, changes no register.
- R7: While the enable bit is 1, the counter advances by one on each cycle with `tick` high. A counter load on the same cycle takes precedence over the advance. While the enable bit is 0, the counter holds.
- R8: When the counter wraps from 0xFF to 0x00 with the mode bit set, the overflow flag is set, and `wdt_ovf` is high for exactly 128 cycles starting on the next cycle.
- R9: If reset enable is 1 at the wrap, an internal reset pulse rises on the same cycle as `wdt_ovf` and stays high for exactly 512 cycles. It appears on `int_rst_por` when the select bit is 0 and on `int_rst_man` when the select bit is 1. If reset enable is 0, neither output rises.
- R10: A wrap with the mode bit clear sets no flag and produces no pulse.
- R11: Asserting `rst_n` at the moment of a wrap, or during a pulse, leaves the overflow flag at 0 and all pulse outputs low. The internal reset pulse clears none of the block's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low. Asserts asynchronously and is released synchronously. |
| tick | input | 1 | Count-enable tick |
| wr_en | input | 1 | Write strobe for one word write |
| addr | input | 2 | Byte offset, used for both reads and writes |
| wr_data | input | 16 | Write word: key in the upper byte, data in the lower byte |
| rd_data | output | 8 | Read byte selected by `addr` |
| wdt_ovf | output | 1 | External overflow pulse, 128 cycles |
| int_rst_por | output | 1 | Internal reset pulse, power-on type, 512 cycles |
| int_rst_man | output | 1 | Internal reset pulse, manual type, 512 cycles |

## Verification
A key decoder that accepts a wrong key shows up in the very next read of offset 0 or offset 3, as a bit that should have held. A stuck flag or an armed bit shows up the same way. A pulse counter that is loaded with the wrong length, or that never reloads, changes how long `wdt_ovf` or the reset output stays high. That error becomes visible 128 or 512 cycles after the wrap, when the output falls at the wrong cycle. A type select that is not captured correctly puts the pulse on the wrong reset output on the very first cycle of the pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W    = 8;
  localparam int OVF_LEN  = 128;
  localparam int RST_LEN  = 512;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 16;

  localparam logic [7:0] KEY_CTRL = 8'hA5;
  localparam logic [7:0] KEY_LOAD = 8'h5A;

  localparam int BIT_MODE = 6;
  localparam int BIT_EN   = 5;
  localparam int BIT_FLAG = 7;
  localparam int BIT_RSTE = 6;
  localparam int BIT_TYPE = 5;

  localparam logic [ADDR_W-1:0] OFS_TCTL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RCTL = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_RRD  = 2'd3;

  typedef struct packed {
    logic mode;
    logic en;
  } tctl_t;

  typedef struct packed {
    logic flag;
    logic rste;
    logic sel_man;
  } rctl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_evt,
  output tctl_t             tctl,
  output rctl_t             rctl,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val
);
  logic [7:0] key;
  logic [7:0] dat;
  logic       key_ctrl, key_load;
  logic       sel_t, sel_r;
  tctl_t      tctl_nxt;
  rctl_t      rctl_nxt;
  logic       tctl_we, rctl_we;

  assign key        = wr_data[DATA_W-1:8];
  assign dat        = wr_data[7:0];
  assign key_ctrl   = (key == KEY_CTRL);
  assign key_load   = (key == KEY_LOAD);
  assign sel_t      = wr_en && (addr == OFS_TCTL);
  assign sel_r      = wr_en && (addr == OFS_RCTL);
  assign cnt_ld     = sel_t && key_load;
  assign cnt_ld_val = dat[CNT_W-1:0];

  always_comb begin
    tctl_nxt = tctl;
    tctl_we  = 1'b0;
    if (sel_t && key_ctrl) begin
      tctl_nxt.mode = dat[BIT_MODE];
      tctl_nxt.en   = dat[BIT_EN];
      tctl_we       = 1'b1;
    end
  end

  always_comb begin
    rctl_nxt = rctl;
    rctl_we  = 1'b0;
    if (sel_r && key_load) begin
      rctl_nxt.rste    = dat[BIT_RSTE];
      rctl_nxt.sel_man = dat[BIT_TYPE];
      rctl_we          = 1'b1;
    end
    if (sel_r && key_ctrl && (dat == 8'h00)) begin
      rctl_nxt.flag = 1'b0;
      rctl_we       = 1'b1;
    end
    if (ovf_evt) begin
      rctl_nxt.flag = 1'b1;
      rctl_we       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tctl <= '0;
    end else if (tctl_we) begin
      tctl <= tctl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rctl <= '0;
    end else if (rctl_we) begin
      rctl <= rctl_nxt;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_nxt;
  logic         cnt_we;

  assign wrap = en && tick && !ld && (cnt == TOP);

  always_comb begin
    cnt_nxt = cnt;
    cnt_we  = 1'b0;
    if (ld) begin
      cnt_nxt = ld_val;
      cnt_we  = 1'b1;
    end else if (en && tick) begin
      cnt_nxt = cnt + 1'b1;
      cnt_we  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);
  logic [CW-1:0] left, left_nxt;
  logic          left_we;

  always_comb begin
    left_nxt = left;
    left_we  = 1'b0;
    if (start) begin
      left_nxt = LEN_V;
      left_we  = 1'b1;
    end else if (left != '0) begin
      left_nxt = left - 1'b1;
      left_we  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (left_we) begin
      left <= left_nxt;
    end
  end

  assign active = (left != '0);
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        rd_data,
  output logic              wdt_ovf,
  output logic              int_rst_por,
  output logic              int_rst_man
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  tctl_t            tctl;
  rctl_t            rctl;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             ovf_evt;
  logic             rst_start;
  logic             rst_active;
  logic             type_man, type_man_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  wdt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .ovf_evt    (ovf_evt),
    .tctl       (tctl),
    .rctl       (rctl),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .en     (tctl.en),
    .tick   (tick),
    .ld     (cnt_ld),
    .ld_val (cnt_ld_val),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  assign ovf_evt   = wrap && tctl.mode;
  assign rst_start = ovf_evt && rctl.rste;

  wdt_pulse #(.LEN(OVF_LEN)) u_ovf_pulse (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (ovf_evt),
    .active (wdt_ovf)
  );

  wdt_pulse #(.LEN(RST_LEN)) u_rst_pulse (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (rst_start),
    .active (rst_active)
  );

  always_comb begin
    type_man_nxt = type_man;
    if (rst_start) type_man_nxt = rctl.sel_man;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      type_man <= 1'b0;
    end else if (rst_start) begin
      type_man <= type_man_nxt;
    end
  end

  assign int_rst_por = rst_active && !type_man;
  assign int_rst_man = rst_active && type_man;

  always_comb begin
    rd_data = 8'h00;
    case (addr)
      OFS_TCTL: begin
        rd_data[BIT_MODE] = tctl.mode;
        rd_data[BIT_EN]   = tctl.en;
      end
      OFS_CNT: rd_data = cnt;
      OFS_RRD: begin
        rd_data[BIT_FLAG] = rctl.flag;
        rd_data[BIT_RSTE] = rctl.rste;
        rd_data[BIT_TYPE] = rctl.sel_man;
      end
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdt_rstctl_chk.sv
module wdt_rstctl_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              ovf_evt,
  input logic              rst_start,
  input logic              wdt_ovf,
  input logic              int_rst_por,
  input logic              int_rst_man,
  input tctl_t             tctl,
  input rctl_t             rctl
);
  logic [9:0] ovf_hi, rst_hi;
  logic       rst_any;
  logic       bad_key;

  assign rst_any = int_rst_por || int_rst_man;
  assign bad_key = wr_en && (wr_data[15:8] != KEY_CTRL) && (wr_data[15:8] != KEY_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_hi <= '0;
      rst_hi <= '0;
    end else begin
      ovf_hi <= ovf_evt ? 10'd0 : (wdt_ovf ? ovf_hi + 10'd1 : 10'd0);
      rst_hi <= rst_start ? 10'd0 : (rst_any ? rst_hi + 10'd1 : 10'd0);
    end
  end

  AST_OVF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_ovf) |-> (ovf_hi == 10'(OVF_LEN))); // R8
  AST_OVF_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi <= 10'(OVF_LEN)); // R8
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_any) |-> (rst_hi == 10'(RST_LEN))); // R9
  AST_RST_WITH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_any) |-> $rose(wdt_ovf)); // R9
  AST_RST_ONE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rst_por && int_rst_man)); // R9
  AST_FLAG_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rctl.flag) |-> $past(ovf_evt)); // R5
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> ($stable(tctl) && $stable(rctl.rste) && $stable(rctl.sel_man))); // R6
  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> tctl.mode); // R10
endmodule

bind wdt_rstctl wdt_rstctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .ovf_evt     (ovf_evt),
  .rst_start   (rst_start),
  .wdt_ovf     (wdt_ovf),
  .int_rst_por (int_rst_por),
  .int_rst_man (int_rst_man),
  .tctl        (tctl),
  .rctl        (rctl)
);

// File: tb/tb_wdt_rstctl.sv
module tb_wdt_rstctl;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [1:0]  addr;
  logic [15:0] wr_data;
  logic [7:0]  rd_data;
  logic        wdt_ovf, int_rst_por, int_rst_man;

  int n_chk = 0;
  int n_fail = 0;

  logic       m_mode, m_en, m_flag, m_rste, m_sel;
  logic [7:0] m_cnt;

  always #(PERIOD/2) clk = ~clk;

  wdt_rstctl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_ovf(wdt_ovf),
    .int_rst_por(int_rst_por), .int_rst_man(int_rst_man)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_mode, m_en, 5'b0};
      2'd1: return m_cnt;
      2'd3: return {m_flag, m_rste, m_sel, 5'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [1:0] a, input logic [15:0] d);
    if (a == 2'd0 && d[15:8] == 8'hA5) begin m_mode = d[6]; m_en = d[5]; end
    if (a == 2'd0 && d[15:8] == 8'h5A) m_cnt = d[7:0];
    if (a == 2'd2 && d[15:8] == 8'h5A) begin m_rste = d[6]; m_sel = d[5]; end
    if (a == 2'd2 && d[15:8] == 8'hA5 && d[7:0] == 8'h00) m_flag = 1'b0;
  endfunction

  task automatic model_clear();
    m_mode = 0; m_en = 0; m_flag = 0; m_rste = 0; m_sel = 0; m_cnt = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check(req, rd_data, exp_rd(2'(a)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_run(input logic rste, input logic sel, input string req);
    int o_hi = 0, p_hi = 0, m_hi = 0;
    // one pulse cycle already elapsed when ticks() returns at the negedge after wrap
    check({req, " rise"}, {wdt_ovf, int_rst_por, int_rst_man},
          {1'b1, rste && !sel, rste && sel});
    for (int i = 0; i < 600; i++) begin
      o_hi += int'(wdt_ovf); p_hi += int'(int_rst_por); m_hi += int'(int_rst_man);
      @(negedge clk);
    end
    check("R8 ovf length", o_hi, 128);
    check({req, " por length"}, p_hi, (rste && !sel) ? 512 : 0);
    check({req, " man length"}, m_hi, (rste && sel) ? 512 : 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 16'h0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    check("R1 pulses", {wdt_ovf, int_rst_por, int_rst_man}, 3'b000);

    // R3 R4 directed writes, R2 layout
    wr(2'd0, 16'hA560); check_all("R3 tctl write");
    wr(2'd0, 16'h5AC3); check_all("R3 cnt load");
    wr(2'd2, 16'h5AFF); check_all("R4 rctl write");
    wr(2'd0, 16'h1234); wr(2'd1, 16'hA500); wr(2'd3, 16'h5A00);
    check_all("R6 bad key or odd offset");
    wr(2'd0, 16'hA500); wr(2'd0, 16'h5A10);
    check_all("R2 layout after clear");

    // R7 counting with enable, holding without
    ticks(5); check_all("R7 hold when disabled");
    wr(2'd0, 16'hA520); ticks(5); m_cnt = m_cnt + 8'd5;
    check_all("R7 count when enabled");

    // R10 wrap in interval mode: no flag, no pulse
    wr(2'd0, 16'h5AFE); wr(2'd2, 16'h5A40); ticks(2); m_cnt = 8'h00;
    check_all("R10 wrap without mode");
    check("R10 no pulse", {wdt_ovf, int_rst_por, int_rst_man}, 3'b000);

    // R8 R9 overflow with power-on type
    wr(2'd0, 16'hA560); wr(2'd0, 16'h5AFD); wr(2'd2, 16'h5A40);
    ticks(3); m_cnt = 8'h00; m_flag = 1'b1;
    pulse_run(1'b1, 1'b0, "R9 por");
    check_all("R8 flag set, R11 regs kept");

    // R5 clear key with nonzero data ignored, then clear
    wr(2'd2, 16'hA501); check_all("R5 nonzero clear ignored");
    wr(2'd2, 16'hA500); check_all("R5 flag cleared");

    // R9 manual type
    wr(2'd2, 16'h5A60); wr(2'd0, 16'h5AFF);
    ticks(1); m_cnt = 8'h00; m_flag = 1'b1;
    pulse_run(1'b1, 1'b1, "R9 man");

    // R9 reset disabled: overflow pulse only
    wr(2'd2, 16'h5A20); wr(2'd0, 16'h5AFF);
    ticks(1); m_cnt = 8'h00;
    pulse_run(1'b0, 1'b1, "R9 disabled");
    check_all("R8 flag after no-reset wrap");

    // R6 random writes against the model
    for (int i = 0; i < 300; i++) begin
      logic [1:0]  a;
      logic [15:0] d;
      int k;
      a = 2'($urandom % 4);
      k = int'($urandom % 4);
      d[7:0]  = 8'($urandom);
      if (($urandom % 4) == 0) d[7:0] = 8'h00;
      d[15:8] = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : 8'($urandom);
      wr(a, d);
      check_all("R6 random write");
    end

    // R11 external reset during pulse, and coinciding with a wrap
    wr(2'd0, 16'hA560); wr(2'd2, 16'h5A40); wr(2'd0, 16'h5AFF);
    ticks(1);
    repeat (10) @(negedge clk);
    do_reset();
    check("R11 reset mid pulse", {wdt_ovf, int_rst_por, int_rst_man}, 3'b000);
    check_all("R11 regs after reset");
    wr(2'd0, 16'hA560); wr(2'd2, 16'h5A40); wr(2'd0, 16'h5AFF);
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    check_all("R11 coincident reset flag 0");
    check("R11 coincident no pulse", {wdt_ovf, int_rst_por, int_rst_man}, 3'b000);

    finish_run();
  end
endmodule